// File: doc/BRIEF.md
# Multi-Slot Reorder Buffer Retire Unit

This block keeps track of instructions that have been dispatched but not yet retired. It holds them in a circular buffer of `DEPTH` slots, where a single instruction may occupy several consecutive slots, one per micro-op. A dispatch stream reserves the slots for one instruction per cycle and hands back a token: the index of the first slot reserved. An execution port later presents that token to mark the instruction as finished. Every cycle the block retires finished instructions strictly in program order, starting at the oldest. It reports the program index of each retired instruction on a set of retire lanes.

The dispatch interface is valid/ready. `disp_ready` is a function of the free-slot count held at the start of the cycle and of the slot count requested on `disp_uops`. It does not depend on `disp_valid`, so a producer may look at it before committing. Asserting `disp_valid` while `disp_ready` is low is a protocol error. The request is ignored and flagged; it is not held over. The execution port and the retire lanes carry no back-pressure. A mark is taken in the cycle it is presented. Every lane that is valid in a cycle is retired at the next clock edge, whether or not anything downstream consumes it.

`MAX_RET` bounds how many instructions can retire in one cycle. A value of 0 removes the bound, and up to `DEPTH` instructions can then retire at once.

Top module: `mslot_retire_ctrl`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: `empty` is 1, `full` is 0, `disp_token` is 0, all `ret_valid` lanes are 0, and both error flags are 0. Any entry marked before the reset is forgotten.
- R2: A dispatch whose `disp_uops` exceeds `DEPTH` reserves exactly `DEPTH` slots.
- R3: A dispatch with `disp_uops` equal to 0 reserves exactly one slot.
- R4: An accepted dispatch returns `disp_token` equal to the allocation pointer in that cycle. The next token is that value plus the reserved slot count, taken modulo `DEPTH`.
- R5: `disp_ready` is 1 exactly when the free-slot count at the start of the cycle is at least the clamped slot count. Slots that retire in the same cycle do not count. `full` is 1 exactly when no slot is free.
- R6: A dispatch presented while `disp_ready` is 0 leaves the buffer state unchanged and sets `err_reserve` to 1 for one cycle, in the next cycle.
- R7: `exec_valid` with an in-range, unmarked token marks that entry. If the entry is at the head of the buffer, it retires on lane 0 in the next cycle, and its program index appears on bits [IDX_W-1:0] of `ret_pidx`.
- R8: Marking a token of `DEPTH` or more, or an entry that is already marked, changes nothing and sets `err_exec` to 1 for one cycle, in the next cycle.
- R9: Retire lane k reports its program index on `ret_pidx` bits [k*IDX_W +: IDX_W]. Valid lanes always form a contiguous group starting at lane 0 and follow program order. Retirement stops at the first unmarked entry or when the buffer runs out of entries.
- R10: At most `MAX_RET` instructions retire per cycle. With `MAX_RET` = 0, up to `DEPTH` instructions retire per cycle.
- R11: Retiring an entry moves the retire pointer past all of that entry's slots and frees them for dispatch from the next cycle. `empty` is 1 exactly when all `DEPTH` slots are free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| disp_valid | input | 1 | Dispatch request valid |
| disp_ready | output | 1 | Enough free slots for the requested count |
| disp_uops | input | UOP_W | Micro-op count of the instruction |
| disp_pidx | input | IDX_W | Program index of the instruction |
| disp_token | output | PTR_W | Token (first slot) assigned on acceptance |
| exec_valid | input | 1 | Execution-done mark valid |
| exec_token | input | PTR_W | Token of the finished instruction |
| ret_valid | output | LANES | Per-lane retire valid, lane 0 oldest |
| ret_pidx | output | LANES*IDX_W | Per-lane retired program index |
| full | output | 1 | No free slot |
| empty | output | 1 | All slots free |
| err_reserve | output | 1 | Dispatch was refused in the previous cycle |
| err_exec | output | 1 | Bad execution mark in the previous cycle |

## Verification
The bench builds two copies of the block, each with `DEPTH` = 5, `UOP_W` = 3 and `IDX_W` = 8. The depth is not a power of two, so tokens 5 to 7 exist and fall outside the buffer. The 3-bit micro-op count can request 0, a normal count, or 6 and 7, which exercises the one-slot minimum and the clamp to `DEPTH`. One copy limits retirement to 2 per cycle; the other uses 0 and can retire all five entries in one cycle. Phased traffic drives each copy through full, empty, refused dispatches, duplicate marks, and out-of-order marks that release retire bursts.

// File: rtl/mslot_retire_pkg.sv
package mslot_retire_pkg;

  // Bits needed to address n slots (at least one).
  function automatic int ptr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of retire lanes: the per-cycle limit, or the whole buffer when unlimited.
  function automatic int lanes_for(input int depth, input int limit);
    return (limit == 0 || limit > depth) ? depth : limit;
  endfunction

endpackage

// File: rtl/mslot_alloc.sv
module mslot_alloc
  import mslot_retire_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int UOP_W = 4,
  localparam int PTR_W = ptr_bits(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [UOP_W-1:0] req_uops,
  input  logic [CNT_W-1:0] ret_slots,
  output logic             req_ready,
  output logic             take,
  output logic [CNT_W-1:0] need,
  output logic [PTR_W-1:0] alloc_ptr,
  output logic [CNT_W-1:0] free_cnt,
  output logic             err_res
);

  logic [PTR_W-1:0] alloc_q;
  logic [CNT_W-1:0] free_q;
  logic [31:0]      req_w;
  logic [CNT_W:0]   asum;
  logic [CNT_W:0]   anext;

  assign req_w = 32'(req_uops);

  // Clamp to the buffer size, with a floor of one slot.
  always_comb begin
    if (req_w == 32'd0)
      need = CNT_W'(1);
    else if (req_w > 32'(DEPTH))
      need = CNT_W'(DEPTH);
    else
      need = CNT_W'(req_w);
  end

  assign req_ready = (free_q >= need);
  assign take      = req_valid && req_ready;

  assign asum  = (CNT_W+1)'(alloc_q) + (CNT_W+1)'(need);
  assign anext = (asum >= (CNT_W+1)'(DEPTH)) ? asum - (CNT_W+1)'(DEPTH) : asum;

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_q <= '0;
      free_q  <= CNT_W'(DEPTH);
      err_res <= 1'b0;
    end else begin
      err_res <= req_valid && !req_ready;
      if (take)
        alloc_q <= PTR_W'(anext);
      free_q <= free_q - (take ? need : '0) + ret_slots;
    end
  end

  assign alloc_ptr = alloc_q;
  assign free_cnt  = free_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CNT_W'(DEPTH)); // R5

  AST_REJECT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> $stable(alloc_ptr)); // R6

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> err_res); // R6

endmodule

// File: rtl/mslot_entry_store.sv
module mslot_entry_store
  import mslot_retire_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int IDX_W = 8,
  localparam int PTR_W = ptr_bits(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [PTR_W-1:0]            wr_ptr,
  input  logic [IDX_W-1:0]            wr_pidx,
  input  logic [CNT_W-1:0]            wr_slots,
  input  logic                        ex_valid,
  input  logic [PTR_W-1:0]            ex_token,
  output logic [DEPTH-1:0]            done_q,
  output logic [DEPTH-1:0][CNT_W-1:0] slots_q,
  output logic [DEPTH-1:0][IDX_W-1:0] pidx_q,
  output logic                        err_ex
);

  logic ex_oob;
  logic ex_bad;

  assign ex_oob = 32'(ex_token) >= 32'(DEPTH);
  assign ex_bad = ex_oob || done_q[ex_token];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= '0;
      slots_q <= '0;
      pidx_q  <= '0;
      err_ex  <= 1'b0;
    end else begin
      err_ex <= ex_valid && ex_bad;
      if (ex_valid && !ex_bad)
        done_q[ex_token] <= 1'b1;
      if (wr_en) begin
        done_q[wr_ptr]  <= 1'b0;
        slots_q[wr_ptr] <= wr_slots;
        pidx_q[wr_ptr]  <= wr_pidx;
      end
    end
  end

  AST_DOUBLE_MARK: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_oob && done_q[ex_token]) |=> err_ex); // R8

  AST_MARK_SETS: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_oob && !done_q[ex_token] && !(wr_en && wr_ptr == ex_token))
      |=> done_q[$past(ex_token)]); // R7

endmodule

// File: rtl/mslot_retire_scan.sv
module mslot_retire_scan
  import mslot_retire_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int IDX_W = 8,
  parameter int LANES = 4,
  localparam int PTR_W = ptr_bits(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            free_cnt,
  input  logic [DEPTH-1:0]            done_q,
  input  logic [DEPTH-1:0][CNT_W-1:0] slots_q,
  input  logic [DEPTH-1:0][IDX_W-1:0] pidx_q,
  output logic [LANES-1:0]            lane_valid,
  output logic [LANES*IDX_W-1:0]      lane_pidx,
  output logic [CNT_W-1:0]            ret_slots
);

  logic [PTR_W-1:0]            head_q;
  logic [LANES:0][PTR_W-1:0]   lp;
  logic [LANES:0][CNT_W-1:0]   acc;
  logic [LANES-1:0][CNT_W-1:0] lo;
  logic [LANES-1:0]            lgo;

  assign lp[0]  = head_q;
  assign acc[0] = '0;
  assign lo[0]  = CNT_W'(DEPTH) - free_cnt;
  assign lgo[0] = 1'b1;

  // One lane per retire opportunity; each lane starts where the previous one ended.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CNT_W-1:0] step;
    logic [CNT_W:0]   sum;
    logic [CNT_W:0]   wrapped;
    logic             hit;

    assign step    = slots_q[lp[k]];
    assign hit     = lgo[k] && (lo[k] != '0) && done_q[lp[k]];
    assign sum     = (CNT_W+1)'(lp[k]) + (CNT_W+1)'(step);
    assign wrapped = (sum >= (CNT_W+1)'(DEPTH)) ? sum - (CNT_W+1)'(DEPTH) : sum;

    assign lp[k+1]  = hit ? PTR_W'(wrapped) : lp[k];
    assign acc[k+1] = hit ? acc[k] + step : acc[k];

    assign lane_valid[k]               = hit;
    assign lane_pidx[k*IDX_W +: IDX_W] = hit ? pidx_q[lp[k]] : '0;

    if (k + 1 < LANES) begin : g_next
      assign lo[k+1]  = hit ? lo[k] - step : lo[k];
      assign lgo[k+1] = hit;
    end
  end

  assign ret_slots = acc[LANES];

  always_ff @(posedge clk) begin
    if (rst)
      head_q <= '0;
    else
      head_q <= lp[LANES];
  end

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lane_valid == '0) |=> $stable(head_q)); // R9

endmodule

// File: rtl/mslot_retire_ctrl.sv
module mslot_retire_ctrl
  import mslot_retire_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int IDX_W   = 8,
  parameter int UOP_W   = 4,
  parameter int MAX_RET = 4,
  localparam int PTR_W  = ptr_bits(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANES  = lanes_for(DEPTH, MAX_RET)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [UOP_W-1:0]       disp_uops,
  input  logic [IDX_W-1:0]       disp_pidx,
  output logic [PTR_W-1:0]       disp_token,
  input  logic                   exec_valid,
  input  logic [PTR_W-1:0]       exec_token,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*IDX_W-1:0] ret_pidx,
  output logic                   full,
  output logic                   empty,
  output logic                   err_reserve,
  output logic                   err_exec
);

  logic                        take;
  logic [CNT_W-1:0]            need;
  logic [CNT_W-1:0]            free_cnt;
  logic [CNT_W-1:0]            ret_slots;
  logic [DEPTH-1:0]            done_q;
  logic [DEPTH-1:0][CNT_W-1:0] slots_q;
  logic [DEPTH-1:0][IDX_W-1:0] pidx_q;

  mslot_alloc #(.DEPTH(DEPTH), .UOP_W(UOP_W)) u_alloc (
    .clk       (clk),
    .rst       (rst),
    .req_valid (disp_valid),
    .req_uops  (disp_uops),
    .ret_slots (ret_slots),
    .req_ready (disp_ready),
    .take      (take),
    .need      (need),
    .alloc_ptr (disp_token),
    .free_cnt  (free_cnt),
    .err_res   (err_reserve)
  );

  mslot_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (take),
    .wr_ptr   (disp_token),
    .wr_pidx  (disp_pidx),
    .wr_slots (need),
    .ex_valid (exec_valid),
    .ex_token (exec_token),
    .done_q   (done_q),
    .slots_q  (slots_q),
    .pidx_q   (pidx_q),
    .err_ex   (err_exec)
  );

  mslot_retire_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LANES(LANES)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .free_cnt   (free_cnt),
    .done_q     (done_q),
    .slots_q    (slots_q),
    .pidx_q     (pidx_q),
    .lane_valid (ret_valid),
    .lane_pidx  (ret_pidx),
    .ret_slots  (ret_slots)
  );

  assign full  = (free_cnt == '0);
  assign empty = (free_cnt == CNT_W'(DEPTH));

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    full |-> !disp_ready); // R5

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    empty |-> (ret_valid == '0)); // R9

  AST_FREE_RETURN: assert property (@(posedge clk) disable iff (rst)
    !take |=> free_cnt == $past(free_cnt) + $past(ret_slots)); // R11

endmodule

// File: tb/sim_mslot_retire_ctrl.sv
module sim_mslot_retire_ctrl;
  localparam int D  = 5;
  localparam int IW = 8;
  localparam int UW = 3;
  localparam int PW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          dv [2];
  logic [UW-1:0] du [2];
  logic [IW-1:0] dp [2];
  logic          ev [2];
  logic [PW-1:0] et [2];
  logic          drdy [2];
  logic [PW-1:0] dtok [2];
  logic [4:0]    rv [2];
  logic [5*IW-1:0] rp [2];
  logic          fu [2], em [2], er [2], ee [2];
  logic [1:0]      u0_rv;
  logic [2*IW-1:0] u0_rp;

  assign rv[0] = {3'b000, u0_rv};
  assign rp[0] = {24'd0, u0_rp};

  mslot_retire_ctrl #(.DEPTH(D), .IDX_W(IW), .UOP_W(UW), .MAX_RET(2)) u0 (
    .clk(clk), .rst(rst), .disp_valid(dv[0]), .disp_ready(drdy[0]), .disp_uops(du[0]),
    .disp_pidx(dp[0]), .disp_token(dtok[0]), .exec_valid(ev[0]), .exec_token(et[0]),
    .ret_valid(u0_rv), .ret_pidx(u0_rp), .full(fu[0]), .empty(em[0]),
    .err_reserve(er[0]), .err_exec(ee[0]));

  mslot_retire_ctrl #(.DEPTH(D), .IDX_W(IW), .UOP_W(UW), .MAX_RET(0)) u1 (
    .clk(clk), .rst(rst), .disp_valid(dv[1]), .disp_ready(drdy[1]), .disp_uops(du[1]),
    .disp_pidx(dp[1]), .disp_token(dtok[1]), .exec_valid(ev[1]), .exec_token(et[1]),
    .ret_valid(rv[1]), .ret_pidx(rp[1]), .full(fu[1]), .empty(em[1]),
    .err_reserve(er[1]), .err_exec(ee[1]));

  int    vectors = 0;
  int    miscompares = 0;
  int    lanes [2] = '{2, 5};
  int    m_alloc [2], m_head [2], m_free [2], m_next [2];
  int    m_pidx [2][D];
  int    m_slots [2][D];
  bit    m_ex [2][D];
  bit    x_er [2], x_ee [2];
  string m_tag [2];
  logic [31:0] seed = 32'h1357_9bdf;
  bit    finished = 1'b0;

  function automatic int rnd(input int n);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed % 32'(n));
  endfunction

  function automatic int clampn(input int u);
    return (u == 0) ? 1 : ((u > D) ? D : u);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mreset();
    for (int i = 0; i < 2; i++) begin
      m_alloc[i] = 0; m_head[i] = 0; m_free[i] = D;
      x_er[i] = 1'b0; x_ee[i] = 1'b0; m_tag[i] = "R1";
      for (int s = 0; s < D; s++) begin
        m_ex[i][s] = 1'b0; m_slots[i][s] = 1; m_pidx[i][s] = 0;
      end
    end
  endtask

  task automatic idle();
    for (int i = 0; i < 2; i++) begin
      dv[i] = 1'b0; du[i] = '0; dp[i] = '0; ev[i] = 1'b0; et[i] = '0;
    end
  endtask

  task automatic chk_reset();
    for (int i = 0; i < 2; i++) begin
      chk(dtok[i] == '0, "R1", "reset disp_token", int'(dtok[i]), 0);
      chk(em[i] == 1'b1, "R1", "reset empty", int'(em[i]), 1);
      chk(fu[i] == 1'b0, "R1", "reset full", int'(fu[i]), 0);
      chk(rv[i] == '0, "R1", "reset ret_valid", int'(rv[i]), 0);
      chk(er[i] == 1'b0 && ee[i] == 1'b0, "R1", "reset errors", int'({er[i], ee[i]}), 0);
    end
  endtask

  task automatic gen(input int i, input int ph);
    int pd;
    int pe;
    pd = (ph == 0) ? 7 : ((ph == 1) ? 2 : 4);
    pe = (ph == 0) ? 2 : ((ph == 1) ? 7 : 4);
    dv[i] = (rnd(8) < pd);
    du[i] = UW'(rnd(8));
    dp[i] = IW'(m_next[i]);
    ev[i] = 1'b0;
    et[i] = '0;
    if (rnd(8) < pe) begin
      if (rnd(8) == 0) begin
        ev[i] = 1'b1;
        et[i] = PW'(rnd(8));
      end else begin
        int cand [D];
        int nc;
        int p;
        int occ;
        nc = 0; p = m_head[i]; occ = D - m_free[i];
        for (int k = 0; k < D; k++) begin
          if (occ > 0) begin
            if (!m_ex[i][p]) begin cand[nc] = p; nc++; end
            occ -= m_slots[i][p];
            p = (p + m_slots[i][p]) % D;
          end
        end
        if (nc > 0) begin
          ev[i] = 1'b1;
          et[i] = PW'(cand[rnd(nc)]);
        end
      end
    end
  endtask

  task automatic check_step(input int i);
    int need;
    int occ;
    int p;
    int rs;
    int t;
    int a;
    bit rdy;
    bit go;
    need = clampn(int'(du[i]));
    rdy  = (m_free[i] >= need);
    chk(drdy[i] == rdy, "R5", "disp_ready", int'(drdy[i]), int'(rdy));
    chk(int'(dtok[i]) == m_alloc[i], m_tag[i], "disp_token", int'(dtok[i]), m_alloc[i]);
    chk(fu[i] == (m_free[i] == 0), "R5", "full", int'(fu[i]), int'(m_free[i] == 0));
    chk(em[i] == (m_free[i] == D), "R11", "empty", int'(em[i]), int'(m_free[i] == D));
    chk(er[i] == x_er[i], "R6", "err_reserve", int'(er[i]), int'(x_er[i]));
    chk(ee[i] == x_ee[i], "R8", "err_exec", int'(ee[i]), int'(x_ee[i]));
    occ = D - m_free[i]; p = m_head[i]; go = 1'b1; rs = 0;
    for (int k = 0; k < lanes[i]; k++) begin
      bit e;
      e = go && (occ > 0) && m_ex[i][p];
      chk(rv[i][k] == e, (k >= 2) ? "R10" : "R9", "ret_valid lane", int'(rv[i][k]), int'(e));
      if (e) begin
        chk(int'(rp[i][k*IW +: IW]) == m_pidx[i][p], "R7", "ret_pidx lane",
            int'(rp[i][k*IW +: IW]), m_pidx[i][p]);
        occ -= m_slots[i][p];
        rs  += m_slots[i][p];
        p = (p + m_slots[i][p]) % D;
      end
      go = e;
    end
    // advance the model across the clock edge
    x_er[i] = dv[i] && !rdy;
    if (dv[i] && rdy)
      m_tag[i] = (du[i] == 0) ? "R3" : ((int'(du[i]) > D) ? "R2" : "R4");
    else if (dv[i])
      m_tag[i] = "R6";
    else
      m_tag[i] = "R4";
    x_ee[i] = 1'b0;
    if (ev[i]) begin
      t = int'(et[i]);
      if (t >= D || m_ex[i][t]) x_ee[i] = 1'b1;
      else m_ex[i][t] = 1'b1;
    end
    if (dv[i] && rdy) begin
      a = m_alloc[i];
      m_pidx[i][a] = int'(dp[i]);
      m_slots[i][a] = need;
      m_ex[i][a] = 1'b0;
      m_alloc[i] = (a + need) % D;
      m_free[i] -= need;
      m_next[i] = (m_next[i] + 1) % 256;
    end
    m_head[i] = p;
    m_free[i] += rs;
  endtask

  initial begin
    rst = 1'b1;
    m_next[0] = 0; m_next[1] = 100;
    idle();
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk_reset();
    rst = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (c == 1500) begin
        idle();
        rst = 1'b1;
        @(negedge clk);
        #1 chk_reset();
        rst = 1'b0;
        mreset();
      end
      for (int i = 0; i < 2; i++) gen(i, (c >> 6) & 3);
      #1;
      for (int i = 0; i < 2; i++) check_step(i);
      @(negedge clk);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule